// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block holds the interrupt flags of a two-channel timer/counter and turns them into one interrupt request. The counter core feeds it one-cycle event pulses (overflow, compare match and capture-valid for each channel) and a synchronization-busy level, plus a qualifier marking that a busy drop comes from an enable or a software reset. A bus write strobe with a data byte clears flags, and a per-channel capture-register read strobe clears that channel's flag when the channel is in capture mode.

The flags are presented as an 8-bit status byte. Each set flag whose enable bit is one requests an interrupt. The request line is a registered OR of those enabled flags. A capture that arrives while its channel flag is still pending has nowhere to go, so it raises an error flag. Set events win over clears that arrive in the same cycle.

Top module: `tfc_intflag`

## Requirements
- R1: After reset, the status byte is 0x00 and the interrupt request is low.
- R2: Status layout: bit 0 overflow, bit 1 error, bit 3 sync-ready, bit 4 channel 0, bit 5 channel 1. Bits 2, 6 and 7 always read zero, and writes cannot set them.
- R3: A write with a one in a flag's bit position clears that flag. A zero in that position leaves the flag unchanged.
- R4: The overflow and channel flags become one at the clock edge that samples the event, so they are visible in the cycle after the event and not in the cycle of the event. In compare mode (mode bit 0) a channel flag is set by its match pulse. In capture mode (mode bit 1) it is set by its capture-valid pulse, and the pulse that does not belong to the mode is ignored.
- R5: In capture mode, a read strobe on a channel's capture register clears that channel's flag. In compare mode the read strobe leaves the flag unchanged.
- R6: In capture mode, a capture-valid pulse on a channel whose flag is already one, with no read of that channel in the same cycle, sets the error flag.
- R7: A one-to-zero transition of the busy input sets the sync-ready flag exactly once per transition. The transition is detected against a registered copy of the previous busy value.
- R8: A busy transition that happens while the enable/reset qualifier is high does not set the sync-ready flag.
- R9: When a set event and a write-one clear for the same flag occur in the same cycle, the flag ends up one.
- R10: The interrupt request is one in the cycle after any flag is one while its enable bit is one. It is zero in the cycle after no enabled flag is one. A flag whose enable bit is zero never raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low reset |
| ovf_evt | input | 1 | Overflow event pulse |
| cmp_hit | input | NUM_CH | Per-channel compare match pulse |
| cap_done | input | NUM_CH | Per-channel capture-valid pulse |
| cap_mode | input | NUM_CH | Per-channel mode: 1 capture, 0 compare |
| cap_rd | input | NUM_CH | Per-channel capture register read strobe |
| busy_i | input | 1 | Synchronization-busy level |
| busy_qual | input | 1 | High when a busy drop comes from an enable or software reset |
| wr_en | input | 1 | Status byte write strobe |
| wr_data | input | STATUS_W | Write data, ones clear flags |
| irq_mask | input | STATUS_W | Per-flag interrupt enable |
| status_o | output | STATUS_W | Flag status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that the event and strobe inputs are synchronous to the clock and stable around each edge. They also assume that the qualifier is valid in the same cycle as the low busy sample that completes a drop. The mode and mask inputs may change at any edge, because every property samples them in the cycle it reasons about. The bench changes inputs only shortly after a rising edge and holds each pulse for exactly one cycle. It changes mode bits only while no event is pending, so every transition the properties watch is a clean single-cycle one.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
   localparam int unsigned TFC_STATUS_W = 8;
   localparam int unsigned TFC_NUM_CH   = 2;
   // positions decoded by software; fixed by the status layout
   localparam int unsigned OVF_POS  = 0;
   localparam int unsigned ERR_POS  = 1;
   localparam int unsigned SRDY_POS = 3;
   localparam int unsigned CH_POS   = 4;
endpackage

// File: rtl/tfc_flag_cell.sv
module tfc_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set dominates a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~clr_i);
   end
endmodule

// File: rtl/tfc_busy_fall.sv
module tfc_busy_fall (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic block_i,
   output logic fall_o
);
   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy_i;
   end

   assign fall_o = busy_q & ~busy_i & ~block_i;
endmodule

// File: rtl/tfc_irq_gen.sv
module tfc_irq_gen #(
   parameter int unsigned W          = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_o
);
   logic any_req;
   assign any_req = |(flags_i & mask_i);

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_req;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         assign irq_o = any_req;
      end
   endgenerate
endmodule

// File: rtl/tfc_intflag.sv
module tfc_intflag
   import tfc_pkg::*;
#(
   parameter int unsigned NUM_CH         = TFC_NUM_CH,
   parameter int unsigned STATUS_W       = TFC_STATUS_W,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ovf_evt,
   input  logic [NUM_CH-1:0]   cmp_hit,
   input  logic [NUM_CH-1:0]   cap_done,
   input  logic [NUM_CH-1:0]   cap_mode,
   input  logic [NUM_CH-1:0]   cap_rd,
   input  logic                busy_i,
   input  logic                busy_qual,
   input  logic                wr_en,
   input  logic [STATUS_W-1:0] wr_data,
   input  logic [STATUS_W-1:0] irq_mask,
   output logic [STATUS_W-1:0] status_o,
   output logic                irq_o
);
   localparam int unsigned TOP_CH = CH_POS + NUM_CH;

   generate
      if (TOP_CH > STATUS_W) begin : g_bad_width
         $error("tfc_intflag: channel flags do not fit the status byte");
      end
      if (NUM_CH == 0) begin : g_bad_ch
         $error("tfc_intflag: at least one channel required");
      end
   endgenerate

   logic [STATUS_W-1:0] wclr;
   assign wclr = wr_en ? wr_data : '0;

   logic [NUM_CH-1:0] ch_q;
   logic [NUM_CH-1:0] lost;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         logic set_c, clr_c;
         assign set_c = cap_mode[gi] ? cap_done[gi] : cmp_hit[gi];
         assign clr_c = wclr[CH_POS+gi] | (cap_mode[gi] & cap_rd[gi]);
         // capture with a pending flag and no freeing read is lost
         assign lost[gi] = cap_mode[gi] & cap_done[gi] & ch_q[gi] & ~cap_rd[gi];
         tfc_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_c),
            .clr_i (clr_c),
            .q_o   (ch_q[gi])
         );
      end
   endgenerate

   logic ovf_q, err_q, srdy_q, busy_fall;

   tfc_flag_cell u_ovf (
      .clk(clk), .rst_n(rst_n), .set_i(ovf_evt), .clr_i(wclr[OVF_POS]), .q_o(ovf_q)
   );

   tfc_flag_cell u_err (
      .clk(clk), .rst_n(rst_n), .set_i(|lost), .clr_i(wclr[ERR_POS]), .q_o(err_q)
   );

   tfc_busy_fall u_fall (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .block_i(busy_qual), .fall_o(busy_fall)
   );

   tfc_flag_cell u_srdy (
      .clk(clk), .rst_n(rst_n), .set_i(busy_fall), .clr_i(wclr[SRDY_POS]), .q_o(srdy_q)
   );

   always_comb begin
      status_o                          = '0;
      status_o[OVF_POS]                 = ovf_q;
      status_o[ERR_POS]                 = err_q;
      status_o[SRDY_POS]                = srdy_q;
      status_o[CH_POS +: NUM_CH]        = ch_q;
   end

   tfc_irq_gen #(
      .W          (STATUS_W),
      .REGISTERED (IRQ_REGISTERED)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (status_o),
      .mask_i  (irq_mask),
      .irq_o   (irq_o)
   );
endmodule

// File: rtl/tfc_intflag_chk.sv
module tfc_intflag_chk
   import tfc_pkg::*;
#(
   parameter int unsigned NUM_CH         = TFC_NUM_CH,
   parameter int unsigned STATUS_W       = TFC_STATUS_W,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ovf_evt,
   input logic [NUM_CH-1:0]   cmp_hit,
   input logic [NUM_CH-1:0]   cap_done,
   input logic [NUM_CH-1:0]   cap_mode,
   input logic [NUM_CH-1:0]   cap_rd,
   input logic                busy_i,
   input logic                busy_qual,
   input logic                wr_en,
   input logic [STATUS_W-1:0] wr_data,
   input logic [STATUS_W-1:0] irq_mask,
   input logic [STATUS_W-1:0] status_o,
   input logic                irq_o
);
   logic alive;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alive <= 1'b0;
      else        alive <= 1'b1;
   end

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[2] == 1'b0 && status_o[STATUS_W-1:CH_POS+NUM_CH] == '0);

   // R4
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> status_o[OVF_POS]);

   // R3
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[OVF_POS] && !ovf_evt) |=> !status_o[OVF_POS]);

   // R5
   cap_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_mode[0] && cap_rd[0] && !cap_done[0]) |=> !status_o[CH_POS]);

   // R6
   lost_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_mode[0] && cap_done[0] && status_o[CH_POS] && !cap_rd[0]) |=> status_o[ERR_POS]);

   // R7
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alive && $fell(busy_i) && !busy_qual) |=> status_o[SRDY_POS]);

   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alive && $fell(busy_i) && busy_qual && !status_o[SRDY_POS]) |=> !status_o[SRDY_POS]);

   generate
      if (IRQ_REGISTERED) begin : g_irq_chk
         // R10
         irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|(status_o & irq_mask)) |=> irq_o);
         // R10
         irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(status_o & irq_mask)) |=> !irq_o);
      end
   endgenerate
endmodule

bind tfc_intflag tfc_intflag_chk #(
   .NUM_CH         (NUM_CH),
   .STATUS_W       (STATUS_W),
   .IRQ_REGISTERED (IRQ_REGISTERED)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ovf_evt   (ovf_evt),
   .cmp_hit   (cmp_hit),
   .cap_done  (cap_done),
   .cap_mode  (cap_mode),
   .cap_rd    (cap_rd),
   .busy_i    (busy_i),
   .busy_qual (busy_qual),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .irq_mask  (irq_mask),
   .status_o  (status_o),
   .irq_o     (irq_o)
);

// File: tb/tfc_intflag_test.sv
module tfc_intflag_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ovf_evt = 1'b0;
   logic [1:0] cmp_hit = '0;
   logic [1:0] cap_done = '0;
   logic [1:0] cap_mode = '0;
   logic [1:0] cap_rd = '0;
   logic       busy_i = 1'b0;
   logic       busy_qual = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] irq_mask = '0;
   logic [7:0] status_o;
   logic       irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tfc_intflag uut (
      .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .cmp_hit(cmp_hit),
      .cap_done(cap_done), .cap_mode(cap_mode), .cap_rd(cap_rd),
      .busy_i(busy_i), .busy_qual(busy_qual), .wr_en(wr_en),
      .wr_data(wr_data), .irq_mask(irq_mask), .status_o(status_o), .irq_o(irq_o)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      wr_en = 1'b1; wr_data = 8'hFF; tick();
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic t_reset();
      check8("R1 status", status_o, 8'h00);
      check8("R1 irq", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_overflow();
      ovf_evt = 1'b1; #1;
      check8("R4 same cycle", status_o, 8'h00);
      tick(); ovf_evt = 1'b0;
      check8("R4 overflow set", status_o, 8'h01);
      wr_en = 1'b1; wr_data = 8'h00; tick(); wr_en = 1'b0;
      check8("R3 zero write", status_o, 8'h01);
      wr_en = 1'b1; wr_data = 8'hFE; tick(); wr_en = 1'b0;
      check8("R3 other bits write", status_o, 8'h01);
      wr_en = 1'b1; wr_data = 8'h01; tick(); wr_en = 1'b0;
      check8("R3 one write clears", status_o, 8'h00);
   endtask

   task automatic t_modes();
      cap_mode = 2'b00; cap_done = 2'b11; tick(); cap_done = 2'b00;
      check8("R4 capture ignored in compare mode", status_o, 8'h00);
      cmp_hit = 2'b10; tick(); cmp_hit = 2'b00;
      check8("R4 compare ch1", status_o, 8'h20);
      clear_all();
      cap_mode = 2'b11; cmp_hit = 2'b11; tick(); cmp_hit = 2'b00;
      check8("R4 match ignored in capture mode", status_o, 8'h00);
      cap_done = 2'b01; tick(); cap_done = 2'b00;
      check8("R4 capture ch0", status_o, 8'h10);
      clear_all();
      cap_mode = 2'b00;
   endtask

   task automatic t_read();
      cap_mode = 2'b01; cap_done = 2'b01; cmp_hit = 2'b10; tick();
      cap_done = 2'b00; cmp_hit = 2'b00;
      check8("R5 setup", status_o, 8'h30);
      cap_rd = 2'b11; tick(); cap_rd = 2'b00;
      check8("R5 read clears only capture channel", status_o, 8'h20);
      clear_all();
      cap_mode = 2'b00;
   endtask

   task automatic t_error();
      cap_mode = 2'b10; cap_done = 2'b10; tick();
      check8("R6 first capture no error", status_o, 8'h20);
      tick(); cap_done = 2'b00;
      check8("R6 second capture error", status_o, 8'h22);
      clear_all();
      cap_done = 2'b10; tick();
      cap_rd = 2'b10; tick(); cap_done = 2'b00; cap_rd = 2'b00;
      check8("R6 read frees slot no error", status_o, 8'h20);
      clear_all();
      cap_mode = 2'b00;
   endtask

   task automatic t_sync();
      busy_i = 1'b1; tick(); tick();
      check8("R7 busy high no flag", status_o, 8'h00);
      busy_i = 1'b0; tick();
      check8("R7 drop sets flag", status_o, 8'h08);
      clear_all();
      tick(); tick();
      check8("R7 once per drop", status_o, 8'h00);
      busy_i = 1'b1; tick();
      busy_i = 1'b0; busy_qual = 1'b1; tick(); busy_qual = 1'b0;
      tick();
      check8("R8 qualified drop ignored", status_o, 8'h00);
   endtask

   task automatic t_layout();
      cap_mode = 2'b01; ovf_evt = 1'b1; cap_done = 2'b01; cmp_hit = 2'b10; tick();
      ovf_evt = 1'b0; cmp_hit = 2'b00;
      busy_i = 1'b1; tick(); cap_done = 2'b00;
      busy_i = 1'b0; tick();
      check8("R2 all flags layout", status_o, 8'h3B);
      clear_all();
      check8("R2 write ones clears all", status_o, 8'h00);
      cap_mode = 2'b00;
   endtask

   task automatic t_priority();
      ovf_evt = 1'b1; wr_en = 1'b1; wr_data = 8'h01; tick();
      ovf_evt = 1'b0; wr_en = 1'b0;
      check8("R9 set beats clear", status_o, 8'h01);
      cmp_hit = 2'b01; wr_en = 1'b1; wr_data = 8'h11; tick();
      cmp_hit = 2'b00; wr_en = 1'b0;
      check8("R9 channel set beats, ovf cleared", status_o, 8'h10);
      clear_all();
   endtask

   task automatic t_irq();
      irq_mask = 8'h10; ovf_evt = 1'b1; tick(); ovf_evt = 1'b0; tick();
      check8("R10 masked flag no irq", {7'd0, irq_o}, 8'h00);
      irq_mask = 8'h01; #1;
      check8("R10 irq registered", {7'd0, irq_o}, 8'h00);
      tick();
      check8("R10 irq raised", {7'd0, irq_o}, 8'h01);
      wr_en = 1'b1; wr_data = 8'h01; tick(); wr_en = 1'b0;
      check8("R10 irq held one cycle after clear", {7'd0, irq_o}, 8'h01);
      tick();
      check8("R10 irq dropped", {7'd0, irq_o}, 8'h00);
      irq_mask = 8'h00;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      #(200000 * 20 - 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      tick(); tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_overflow();
      t_modes();
      t_read();
      t_error();
      t_sync();
      t_layout();
      t_priority();
      t_irq();
      finish_run();
   end
endmodule